// File: doc/BRIEF.md
# Auto-Reload Up-Counting Timer

This block is an 8-bit timer that counts upward. Its count clock is a single-cycle enable taken from one of four taps of a shared divider. The taps run at 2 Hz, 8 Hz, 32 Hz and 256 Hz, derived from a 32.768 kHz base. Software sets a reload value through a 4-bit register bus in two halves. The counter starts from that value and climbs one step on each selected tick. When it arrives at all-ones it raises a one-cycle interrupt request. On the next selected tick it returns to the reload value by itself. The timer keeps counting whenever it is enabled, whether or not the processor is halted.

The bus has four addresses: control, count low nibble and count high nibble, plus one spare. Writing the low nibble only stages it. Writing the high nibble commits the full byte as the reload value and as the current count. Reading the low nibble returns the live low half and freezes the live high half. A following read of the high nibble therefore forms a consistent byte even if a tick lands between the two reads. The bus carries no streaming data, so it has no valid/ready pair and applies no back-pressure. A strobe is accepted in the cycle it is high, and read data appears one cycle later.

Top module: `rtmr_top`

## Requirements
- R1: After reset the count, reload value, staged nibble, frozen high nibble, control register, `irq` and `reg_rdata` are all zero.
- R2: The control register is at address 0. Bits [1:0] select the tap: 00 uses `tick_in[0]` (2 Hz), 01 uses `tick_in[1]` (8 Hz), 10 uses `tick_in[2]` (32 Hz) and 11 uses `tick_in[3]` (256 Hz). In a cycle where the timer runs and the selected tap is high, the count advances by one. Pulses on the other taps have no effect.
- R3: Bit 2 of the control register is the run enable. While it is 0, the count holds whatever the taps do.
- R4: A write to address 1 stores `reg_wdata` as the staged low nibble and leaves the count and reload value unchanged.
- R5: A write to address 2 sets both the reload value and the count to {`reg_wdata`, staged nibble} at the next edge. This write takes priority over a tick in the same cycle.
- R6: `irq` is high for exactly the one cycle after an edge where a tick moved the count to FF. This includes a reload that lands on FF. A bus write never raises `irq`.
- R7: A tick taken while the count is FF loads the reload value instead of incrementing.
- R8: A read of address 1 returns count[3:0] on `reg_rdata` one cycle later and freezes count[7:4]. A read of address 2 returns the frozen nibble one cycle later.
- R9: A read of address 0 returns {0, run, select} with bit 3 zero. Address 3 reads as zero, and writes to it change nothing.
- R10: `reg_rdata` keeps its value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 4 | Divider tap enables, bit i is tap i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | One-cycle interrupt request on reaching FF |

## Verification
Directed stimulus covers several cases:
- Pulses on unselected taps against the selected one, which separates correct tap decoding from an OR of all taps.
- A stopped timer given ticks.
- A low-nibble write that must not disturb the count.
- A run to FF followed by a further tick, which tells an immediate reload apart from a reload on the next tick.
- A tick landing between the two halves of a read, which exposes a missing snapshot.
- A reload value of FF.
- A load and a tick in the same cycle.

Random phases then mix tap patterns, run/select changes, loads and reads. They compare `irq` and `reg_rdata` every cycle against a reference model, which catches off-by-one and priority errors that the fixed cases do not reach.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtmr_tick_select.sv
module rtmr_tick_select #(
  parameter int N_TAPS = 4,
  localparam int SEL_W = $clog2(N_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tick_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              run,
  output logic              step
);
  logic [N_TAPS-1:0] hit;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign hit[i] = tick_in[i] && (sel == SEL_W'(i));
  end

  assign step = run && (|hit);

  // R3
  step_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> run);
  // R2
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick_in != '0));
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] PRE_TOP = TOP - 1'b1;

  logic [CNT_W-1:0] reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      irq    <= 1'b0;
    end else if (load_en) begin
      count  <= load_val;
      reload <= load_val;
      irq    <= 1'b0;
    end else if (step) begin
      if (count == TOP) begin
        count <= reload;
        irq   <= (reload == TOP);
      end else begin
        count <= count + 1'b1;
        irq   <= (count == PRE_TOP);
      end
    end else begin
      irq <= 1'b0;
    end
  end

  // R6
  irq_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == TOP));
  // R6
  irq_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(step));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_en) |=> $stable(count));
  // R7
  wrap_to_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && count == TOP) |=> (count == $past(reload)));
  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val) && !irq));
endmodule

// File: rtl/rtmr_regfile.sv
module rtmr_regfile
  import rtmr_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int N_TAPS = 4,
  localparam int SEL_W = $clog2(N_TAPS),
  localparam int CNT_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [NIB_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] count,
  output logic [NIB_W-1:0] reg_rdata,
  output logic [SEL_W-1:0] sel,
  output logic             run,
  output logic             load_en,
  output logic [CNT_W-1:0] load_val
);
  reg_addr_e        addr;
  logic [NIB_W-1:0] staged_lo;
  logic [NIB_W-1:0] frozen_hi;
  logic [NIB_W-1:0] rd_mux;

  assign addr     = reg_addr_e'(reg_addr);
  assign load_en  = reg_wr && (addr == ADDR_CNT_HI);
  assign load_val = {reg_wdata, staged_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= '0;
      run       <= 1'b0;
      staged_lo <= '0;
    end else if (reg_wr) begin
      case (addr)
        ADDR_CTRL: begin
          sel <= reg_wdata[SEL_W-1:0];
          run <= reg_wdata[SEL_W];
        end
        ADDR_CNT_LO: staged_lo <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:   rd_mux = NIB_W'({run, sel});
      ADDR_CNT_LO: rd_mux = count[NIB_W-1:0];
      ADDR_CNT_HI: rd_mux = frozen_hi;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      frozen_hi <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
      if (addr == ADDR_CNT_LO) frozen_hi <= count[CNT_W-1:NIB_W];
    end
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  // R8
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && addr == ADDR_CNT_LO) |=> (reg_rdata == $past(count[NIB_W-1:0])));
  // R9
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && addr == ADDR_SPARE) |=> (reg_rdata == '0));
  // R4
  lo_write_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr == ADDR_CNT_LO) |=> $stable(sel) && $stable(run));
endmodule

// File: rtl/rtmr_top.sv
module rtmr_top #(
  parameter int NIB_W  = 4,
  parameter int N_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tick_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [NIB_W-1:0]  reg_wdata,
  output logic [NIB_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * NIB_W;
  localparam int SEL_W = $clog2(N_TAPS);

  logic [SEL_W-1:0] sel;
  logic             run;
  logic             step;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;

  rtmr_regfile #(.NIB_W(NIB_W), .N_TAPS(N_TAPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count(count),
    .reg_rdata(reg_rdata), .sel(sel), .run(run),
    .load_en(load_en), .load_val(load_val)
  );

  rtmr_tick_select #(.N_TAPS(N_TAPS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .sel(sel),
    .run(run), .step(step)
  );

  rtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load_en(load_en),
    .load_val(load_val), .count(count), .irq(irq)
  );
endmodule

// File: tb/rtmr_top_tb_top.sv
module rtmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick_in = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       irq;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  rtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_cnt, m_rel;
  logic [3:0] m_stage, m_frz, m_rdata;
  logic [1:0] m_sel;
  logic       m_run, m_irq;

  function automatic logic [3:0] exp_read(input logic [1:0] a, input logic [7:0] c,
                                          input logic [3:0] f, input logic r,
                                          input logic [1:0] s);
    case (a)
      2'd0: return {1'b0, r, s};
      2'd1: return c[3:0];
      2'd2: return f;
      default: return 4'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_rel <= '0; m_stage <= '0; m_frz <= '0;
      m_rdata <= '0; m_sel <= '0; m_run <= 1'b0; m_irq <= 1'b0;
    end else begin
      if (reg_rd) begin
        m_rdata <= exp_read(reg_addr, m_cnt, m_frz, m_run, m_sel);
        if (reg_addr == 2'd1) m_frz <= m_cnt[7:4];
      end
      if (reg_wr && reg_addr == 2'd0) begin m_sel <= reg_wdata[1:0]; m_run <= reg_wdata[2]; end
      if (reg_wr && reg_addr == 2'd1) m_stage <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) begin
        m_cnt <= {reg_wdata, m_stage}; m_rel <= {reg_wdata, m_stage}; m_irq <= 1'b0;
      end else if (m_run && tick_in[m_sel]) begin
        if (m_cnt == 8'hFF) begin m_cnt <= m_rel; m_irq <= (m_rel == 8'hFF); end
        else begin m_cnt <= m_cnt + 8'd1; m_irq <= (m_cnt == 8'hFE); end
      end else m_irq <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(irq == m_irq, "R6 irq vs model", irq, m_irq);
      check(reg_rdata == m_rdata, "R8 rdata vs model", reg_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] t);
    @(negedge clk); tick_in = t;
    @(negedge clk); tick_in = '0;
  endtask

  task automatic read_count(output logic [7:0] c);
    logic [3:0] lo, hi;
    bus_read(2'd1, lo);
    bus_read(2'd2, hi);
    c = {hi, lo};
  endtask

  initial begin
    logic [7:0] c;
    logic [3:0] d, lo, hi;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(reg_rdata == 4'h0, "R1 rdata after reset", reg_rdata, 0);
    cmp_on = 1'b1;
    bus_read(2'd0, d); check(d == 4'h0, "R1 control after reset", d, 0);
    read_count(c); check(c == 8'h00, "R1 count after reset", c, 0);
    // R4
    bus_write(2'd1, 4'h5);
    read_count(c); check(c == 8'h00, "R4 low write only stages", c, 0);
    // R5
    bus_write(2'd2, 4'hF);
    read_count(c); check(c == 8'hF5, "R5 high write loads", c, 8'hF5);
    // R9
    bus_write(2'd0, 4'h6);
    bus_read(2'd0, d); check(d == 4'h6, "R9 control readback", d, 6);
    // R2
    pulse(4'b1011);
    read_count(c); check(c == 8'hF5, "R2 unselected taps ignored", c, 8'hF5);
    pulse(4'b0100);
    read_count(c); check(c == 8'hF6, "R2 selected tap advances", c, 8'hF6);
    // R3
    bus_write(2'd0, 4'h2);
    pulse(4'b1111);
    read_count(c); check(c == 8'hF6, "R3 stopped holds", c, 8'hF6);
    bus_write(2'd0, 4'h6);
    for (int i = 0; i < 8; i++) pulse(4'b0100);
    check(irq == 1'b0, "R6 no irq before FF", irq, 0);
    pulse(4'b0100);
    check(irq == 1'b1, "R6 irq on reaching FF", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R6 irq one cycle", irq, 0);
    read_count(c); check(c == 8'hFF, "R7 FF held until next tick", c, 8'hFF);
    pulse(4'b0100);
    read_count(c); check(c == 8'hF5, "R7 reload on next tick", c, 8'hF5);
    // R8
    bus_read(2'd1, lo);
    pulse(4'b0100);
    bus_read(2'd2, hi);
    check({hi, lo} == 8'hF5, "R8 snapshot consistent", {hi, lo}, 8'hF5);
    // R9
    bus_write(2'd3, 4'hF);
    bus_read(2'd3, d); check(d == 4'h0, "R9 spare reads zero", d, 0);
    bus_read(2'd0, d); check(d == 4'h6, "R9 spare write ignored", d, 6);
    read_count(c); check(c == 8'hF6, "R9 spare write keeps count", c, 8'hF6);
    // R6 reload value FF
    bus_write(2'd1, 4'hF);
    bus_write(2'd2, 4'hF);
    check(irq == 1'b0, "R6 write never raises irq", irq, 0);
    pulse(4'b0100);
    check(irq == 1'b1, "R6 reload landing on FF", irq, 1);
    read_count(c); check(c == 8'hFF, "R7 reload of FF", c, 8'hFF);
    // R5 load beats tick
    bus_write(2'd0, 4'h4);
    bus_write(2'd1, 4'h3);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 4'h1; tick_in = 4'b0001;
    @(negedge clk); reg_wr = 1'b0; tick_in = '0;
    read_count(c); check(c == 8'h13, "R5 load wins over tick", c, 8'h13);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      tick_in = 4'($urandom) & 4'($urandom) & 4'($urandom);
      reg_rd = ($urandom % 4) == 0;
      reg_wr = ($urandom % 16) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = 4'($urandom);
      if (reg_wr && reg_addr == 2'd0) reg_wdata[2] = ($urandom % 8) != 0;
      if (reg_wr && reg_addr == 2'd2 && ($urandom % 2)) reg_wdata = 4'hF;
    end
    @(negedge clk);
    tick_in = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule